// File: doc/BRIEF.md
# Light-Load Mode Detector Sequencer

This block decides when a digitally controlled buck converter should stop switching at a fixed frequency and move to pulse-frequency operation. It also orders the enables of the surrounding blocks during that change. Load current is estimated from two digitized voltages. The estimate is the averaged switch-node code minus the output-voltage code, which is the DC drop across the inductor's winding resistance. A negative difference counts as zero load.

While the detector is enabled and the converter runs in PWM mode, the estimate must stay below a programmable threshold for a continuous window of clock cycles. Only then is light-load mode entered. The default window is 500 cycles, which is 500 µs at a 1 MHz detector clock. That window is far longer than a load transient takes to settle, so transients cannot cause a false entry.

On entry the block raises three outputs together: the mode flag, the modulator/ADC power-down enable and the duty-source select. The duty-source select hands duty control from the PID path to the hysteretic comparator. The exit is triggered by an external heavy-load detector, or by dropping the detector enable. The exit is staged in a fixed order: the flag drops first, then the modulator and ADCs are powered back up, and after a programmable wake-up gap duty control returns to the PID.

Top module: `lightload_seq`

## Requirements
- R1: After synchronous reset `light_mode`, `mod_adc_off` and `duty_hyst_sel` are all low (PWM operation).
- R2: The load estimate is `vsw_code - vout_code`, taken as a signed difference. A negative difference is treated as an estimate of zero, which is below any non-zero threshold.
- R3: With `det_en` high in PWM mode, once the inputs give an estimate below the active threshold and hold it, `light_mode` rises exactly WINDOW+2 cycles after the inputs are applied. It is still low one cycle earlier.
- R4: An estimate equal to or above the threshold restarts the qualification count. Entry then needs a full new window, counted from the first low sample that follows.
- R5: While `det_en` is low in PWM mode no qualification takes place, and the outputs stay low however long the estimate stays low.
- R6: On entry, `light_mode`, `mod_adc_off` and `duty_hyst_sel` all rise in the same cycle.
- R7: In light-load mode, `heavy_det` high starts the exit sequence. In the first cycle `light_mode` is low while both enables remain high. In the next cycle `mod_adc_off` is low and `duty_hyst_sel` is still high. `duty_hyst_sel` falls `wake_dly`+1 cycles after that.
- R8: Driving `det_en` low in light-load mode produces the same ordered exit as R7.
- R9: `wake_dly` is captured when the exit starts. The threshold is captured while no qualification count is running. Changes to either during a running sequence or window take effect only on the next one.
- R10: `heavy_det` has no effect outside light-load mode. It neither blocks qualification in PWM mode nor alters an exit sequence already under way.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Detector clock |
| rst | input | 1 | Synchronous active-high reset |
| det_en | input | 1 | Detector enable |
| vsw_code | input | VW | Digitized averaged switch-node voltage |
| vout_code | input | VW | Digitized output voltage |
| thr_code | input | VW | Light-load current threshold (estimate units) |
| wake_dly | input | DLYW | Extra wake-up cycles before PID regains duty control |
| heavy_det | input | 1 | Heavy-load indication from the separate detector |
| light_mode | output | 1 | High while light-load mode is active |
| mod_adc_off | output | 1 | Powers down the modulator and ADCs |
| duty_hyst_sel | output | 1 | Selects the hysteretic comparator as duty source |

## Verification
The embedded assertions check rules that must hold on every cycle:
- The flag falls while both enables are still high.
- The duty select never falls while the modulator is still off.
- All three outputs rise together.
- Entry only follows a completed window.
- The qualification count resets whenever the detector is disarmed or a sample reaches the threshold.
- A negative difference yields a zero estimate.

The exact cycle counts cannot be covered by those properties. Only the bench scenarios show them: entry at WINDOW+2, restart after an equal sample, the wake-up gap that follows a delay value changed mid-exit, and the threshold held during a running window.

// File: rtl/llm_pkg.sv
package llm_pkg;

    localparam int CODE_W_DEF   = 10;
    localparam int WINDOW_DEF   = 500;
    localparam int DLY_W_DEF    = 8;

    typedef enum logic [1:0] {
        ST_PWM   = 2'd0,
        ST_LIGHT = 2'd1,
        ST_DROP  = 2'd2,
        ST_WAKE  = 2'd3
    } mode_st_e;

    typedef struct packed {
        logic light;
        logic adc_off;
        logic hyst;
    } hand_out_t;

    function automatic hand_out_t decode_state(mode_st_e st);
        hand_out_t o;
        o.light   = (st == ST_LIGHT);
        o.adc_off = (st == ST_LIGHT) || (st == ST_DROP);
        o.hyst    = (st != ST_PWM);
        return o;
    endfunction

endpackage

// File: rtl/llm_load_est.sv
module llm_load_est #(
    parameter int VW = llm_pkg::CODE_W_DEF
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [VW-1:0] vsw,
    input  logic [VW-1:0] vout,
    output logic [VW-1:0] est
);
    logic signed [VW:0] diff;

    assign diff = $signed({1'b0, vsw}) - $signed({1'b0, vout});

    always_ff @(posedge clk) begin
        if (rst) begin
            est <= '0;
        end else if (diff[VW]) begin
            est <= '0;
        end else begin
            est <= diff[VW-1:0];
        end
    end

    AST_NEG_CLAMP: assert property (@(posedge clk) disable iff (rst)
        (vsw < vout) |=> (est == '0)); // R2

    AST_EST_BOUND: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (est <= $past(vsw))); // R2

endmodule

// File: rtl/llm_qual_timer.sv
module llm_qual_timer #(
    parameter int VW     = llm_pkg::CODE_W_DEF,
    parameter int WINDOW = llm_pkg::WINDOW_DEF
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          armed,
    input  logic [VW-1:0] est,
    input  logic [VW-1:0] thr,
    output logic          qual
);
    localparam int            CW    = $clog2(WINDOW + 1);
    localparam logic [CW-1:0] WIN_C = CW'(WINDOW);

    logic [CW-1:0] cnt;
    logic [VW-1:0] thr_act;
    logic          below;

    assign below = (est < thr_act);
    assign qual  = (cnt == WIN_C);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt     <= '0;
            thr_act <= '0;
        end else begin
            if (cnt == '0) begin
                thr_act <= thr;
            end
            if (!armed || !below) begin
                cnt <= '0;
            end else if (cnt != WIN_C) begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    AST_CNT_RESTART: assert property (@(posedge clk) disable iff (rst)
        (!armed || (est >= thr_act)) |=> (cnt == '0)); // R4

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
        cnt <= WIN_C); // R3

    AST_THR_HELD: assert property (@(posedge clk) disable iff (rst)
        (cnt != '0) |=> (thr_act == $past(thr_act))); // R9

endmodule

// File: rtl/llm_handover_fsm.sv
module llm_handover_fsm #(
    parameter int DLYW = llm_pkg::DLY_W_DEF
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            det_en,
    input  logic            qual,
    input  logic            heavy,
    input  logic [DLYW-1:0] wake_dly,
    output logic            armed,
    output llm_pkg::hand_out_t outs
);
    import llm_pkg::*;

    mode_st_e        state;
    logic [DLYW-1:0] wk_q;
    logic [DLYW-1:0] wcnt;

    assign armed = det_en && (state == ST_PWM);
    assign outs  = decode_state(state);

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_PWM;
            wk_q  <= '0;
            wcnt  <= '0;
        end else begin
            unique case (state)
                ST_PWM: begin
                    if (det_en && qual) begin
                        state <= ST_LIGHT;
                    end
                end
                ST_LIGHT: begin
                    if (heavy || !det_en) begin
                        state <= ST_DROP;
                        wk_q  <= wake_dly;
                    end
                end
                ST_DROP: begin
                    state <= ST_WAKE;
                    wcnt  <= '0;
                end
                ST_WAKE: begin
                    if (wcnt == wk_q) begin
                        state <= ST_PWM;
                    end else begin
                        wcnt <= wcnt + 1'b1;
                    end
                end
                default: state <= ST_PWM;
            endcase
        end
    end

    AST_ENTRY_QUAL: assert property (@(posedge clk) disable iff (rst)
        $rose(outs.light) |-> $past(qual)); // R3

    AST_ENTRY_ALL: assert property (@(posedge clk) disable iff (rst)
        $rose(outs.light) |-> (outs.adc_off && outs.hyst)); // R6

    AST_FLAG_FIRST: assert property (@(posedge clk) disable iff (rst)
        $fell(outs.light) |-> (outs.adc_off && outs.hyst)); // R7

    AST_ADC_BEFORE_MUX: assert property (@(posedge clk) disable iff (rst)
        $fell(outs.hyst) |-> (!outs.adc_off && !outs.light)); // R7

    AST_WAKE_LIMIT: assert property (@(posedge clk) disable iff (rst)
        (state == ST_WAKE) |-> (wcnt <= wk_q)); // R9

endmodule

// File: rtl/lightload_seq.sv
module lightload_seq #(
    parameter int VW     = llm_pkg::CODE_W_DEF,
    parameter int WINDOW = llm_pkg::WINDOW_DEF,
    parameter int DLYW   = llm_pkg::DLY_W_DEF
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            det_en,
    input  logic [VW-1:0]   vsw_code,
    input  logic [VW-1:0]   vout_code,
    input  logic [VW-1:0]   thr_code,
    input  logic [DLYW-1:0] wake_dly,
    input  logic            heavy_det,
    output logic            light_mode,
    output logic            mod_adc_off,
    output logic            duty_hyst_sel
);
    import llm_pkg::*;

    logic [VW-1:0] est;
    logic          qual;
    logic          armed;
    hand_out_t     outs;

    llm_load_est #(.VW(VW)) u_est (
        .clk  (clk),
        .rst  (rst),
        .vsw  (vsw_code),
        .vout (vout_code),
        .est  (est)
    );

    llm_qual_timer #(.VW(VW), .WINDOW(WINDOW)) u_timer (
        .clk   (clk),
        .rst   (rst),
        .armed (armed),
        .est   (est),
        .thr   (thr_code),
        .qual  (qual)
    );

    llm_handover_fsm #(.DLYW(DLYW)) u_fsm (
        .clk      (clk),
        .rst      (rst),
        .det_en   (det_en),
        .qual     (qual),
        .heavy    (heavy_det),
        .wake_dly (wake_dly),
        .armed    (armed),
        .outs     (outs)
    );

    assign light_mode    = outs.light;
    assign mod_adc_off   = outs.adc_off;
    assign duty_hyst_sel = outs.hyst;

    AST_LIGHT_IMPLIES_EN: assert property (@(posedge clk) disable iff (rst)
        light_mode |-> (mod_adc_off && duty_hyst_sel)); // R6

    AST_NO_ENTRY_DISABLED: assert property (@(posedge clk) disable iff (rst)
        $rose(light_mode) |-> $past(det_en)); // R5

endmodule

// File: tb/lightload_seq_bench.sv
module lightload_seq_bench;
    localparam int VW  = 10;
    localparam int W   = 500;
    localparam int DW  = 8;

    typedef struct {
        int        cyc;
        logic [2:0] exp;
        string     tag;
    } item_t;

    logic          clk = 1'b0;
    logic          rst;
    logic          det_en;
    logic [VW-1:0] vsw_code, vout_code, thr_code;
    logic [DW-1:0] wake_dly;
    logic          heavy_det;
    logic          light_mode, mod_adc_off, duty_hyst_sel;

    int    cyc = 0;
    int    n_chk = 0;
    int    n_bad = 0;
    item_t sb[$];

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    lightload_seq #(.VW(VW), .WINDOW(W), .DLYW(DW)) u_lightload_seq (
        .clk(clk), .rst(rst), .det_en(det_en),
        .vsw_code(vsw_code), .vout_code(vout_code), .thr_code(thr_code),
        .wake_dly(wake_dly), .heavy_det(heavy_det),
        .light_mode(light_mode), .mod_adc_off(mod_adc_off),
        .duty_hyst_sel(duty_hyst_sel)
    );

    // expected bit order: {light_mode, mod_adc_off, duty_hyst_sel}
    task automatic expect_at(input int dc, input logic [2:0] e, input string tag);
        item_t it;
        it.cyc = cyc + dc;
        it.exp = e;
        it.tag = tag;
        sb.push_back(it);
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    // monitor: pops items due this cycle and compares
    always @(negedge clk) begin
        for (int i = sb.size() - 1; i >= 0; i--) begin
            if (sb[i].cyc == cyc) begin
                n_chk++;
                if ({light_mode, mod_adc_off, duty_hyst_sel} !== sb[i].exp) begin
                    n_bad++;
                    $display("FAIL %s: cycle %0d got %b expected %b", sb[i].tag, cyc,
                             {light_mode, mod_adc_off, duty_hyst_sel}, sb[i].exp);
                end
                sb.delete(i);
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        rst = 1'b1; det_en = 1'b0; heavy_det = 1'b0;
        vsw_code = 10'd200; vout_code = 10'd100; thr_code = 10'd20; wake_dly = 8'd3;
        step(3);
        rst = 1'b0;
        expect_at(1, 3'b000, "R1 reset state");
        step(5);

        // R5: detector disabled, low load for longer than a window
        vsw_code = 10'd100; vout_code = 10'd100;
        expect_at(W + 2, 3'b000, "R5 no entry while disabled");
        expect_at(W + 20, 3'b000, "R5 still PWM");
        step(W + 21);
        vsw_code = 10'd200; det_en = 1'b1;
        step(5);

        // R3/R6/R2: negative difference counts as zero load
        vsw_code = 10'd100; vout_code = 10'd200;
        expect_at(W + 1, 3'b000, "R3 not yet entered");
        expect_at(W + 2, 3'b111, "R6 R2 entry all enables");
        step(W + 5);
        vsw_code = 10'd200; vout_code = 10'd100;
        expect_at(3, 3'b111, "R3 holds light mode");
        step(3);

        // R7 exit via heavy detector, R9 wake delay latched, R10 heavy during exit
        heavy_det = 1'b1;
        expect_at(1, 3'b011, "R7 flag drops first");
        expect_at(2, 3'b001, "R7 adc released");
        expect_at(5, 3'b001, "R9 wake gap held");
        expect_at(6, 3'b000, "R7 mux released");
        step(1);
        wake_dly = 8'd0;
        step(10);
        heavy_det = 1'b0;
        step(5);

        // R4: equal sample restarts the window
        vsw_code = 10'd110;
        expect_at(W + 2, 3'b000, "R4 no entry after restart");
        step(300);
        vsw_code = 10'd120;
        step(1);
        vsw_code = 10'd110;
        expect_at(W + 1, 3'b000, "R4 window not complete");
        expect_at(W + 2, 3'b111, "R4 entry after full window");
        step(W + 5);

        // R8: detector disable forces exit
        vsw_code = 10'd200;
        det_en = 1'b0;
        expect_at(1, 3'b011, "R8 flag drops first");
        expect_at(2, 3'b001, "R8 adc released");
        expect_at(3, 3'b000, "R8 mux released");
        step(5);
        det_en = 1'b1;
        step(5);

        // R9: threshold held during running window
        vsw_code = 10'd110;
        expect_at(W + 1, 3'b000, "R9 not yet entered");
        expect_at(W + 2, 3'b111, "R9 threshold change ignored mid-window");
        step(100);
        thr_code = 10'd5;
        step(W);
        vsw_code = 10'd200;
        heavy_det = 1'b1;
        step(10);
        heavy_det = 1'b0;
        thr_code = 10'd20;
        expect_at(2, 3'b000, "R9 back in PWM");
        step(5);

        // R10: heavy indication does not block qualification
        heavy_det = 1'b1;
        vsw_code = 10'd5; vout_code = 10'd1000;
        expect_at(W + 1, 3'b000, "R10 not yet entered");
        expect_at(W + 2, 3'b111, "R10 entry despite heavy");
        expect_at(W + 3, 3'b011, "R10 immediate exit");
        expect_at(W + 4, 3'b001, "R10 adc released");
        expect_at(W + 5, 3'b000, "R10 mux released");
        step(W + 6);
        vsw_code = 10'd200; vout_code = 10'd100;
        heavy_det = 1'b0;
        step(5);

        if (sb.size() != 0) begin
            n_bad += sb.size();
            $display("FAIL scoreboard: got %0d pending expected 0", sb.size());
        end
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule